// File: doc/BRIEF.md
# Rowhammer Victim-Refresh Scheduler

This block sits behind a per-row activation counter. When that counter reports that a row has been activated often enough to endanger its neighbours, the row address is pushed into a small in-order queue. Each queued aggressor is later expanded into a burst of refreshes covering every row within a configurable distance on both sides of it. The aggressor row itself is never refreshed.

Service normally happens inside the slack of a periodic refresh command from the memory controller. Each such command grants a bounded number of aggressor entries. If the queue fills up, the block pulls an active-low alert line low so that the controller stops sending new commands. While the alert is low, the block drains the queue on its own. It releases the alert once occupancy has fallen below a low-water mark.

The front end is never dropped on the floor. A full queue simply withholds ready until space returns.

Top module: `rh_victim_sched`

## Requirements
- R1: An enqueue is taken on a clock edge where `enq_valid` and `enq_ready` are both high. `enq_ready` is low exactly while the queue holds `DEPTH` entries. A request held during that time is accepted later and is serviced like any other.
- R2: While `alert_n` is high and no refresh command arrives, queued entries are not serviced. No strobe appears and `busy` stays low.
- R3: A refresh command sampled while idle, with a non-empty queue, starts service. The first victim slot is visible in the cycle after the command edge. For aggressor A and radius `RADIUS`, the slots go one per cycle through A-RADIUS..A-1 and then A+1..A+RADIUS, so one entry takes 2*`RADIUS` cycles.
- R4: A victim address below 0 or at or above `NUM_ROWS` is skipped: `vref_valid` stays low for that slot. The slot still takes its cycle.
- R5: One refresh command services at most `PER_REF` entries, back to back with no idle cycle between them. Remaining entries wait for a later command.
- R6: Entries are serviced in the order they were accepted.
- R7: `alert_n` goes low in the cycle after the edge at which occupancy first equals `DEPTH`.
- R8: Once low, `alert_n` stays low until an edge samples occupancy below `LOW_MARK`. It goes high in the cycle after that edge.
- R9: While `alert_n` is low, the block pops and services entries continuously without a refresh command. It starts in the cycle after the alert is raised.
- R10: `busy` is high exactly during the cycles in which victim slots are being stepped through.
- R11: A refresh command that arrives while `busy` is high has no effect. It neither extends the current grant nor starts a new one.
- R12: After reset, `enq_ready` is high, `alert_n` is high, and both `busy` and `vref_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Aggressor row offered by the counting front end |
| enq_row | input | ROW_W | Aggressor row address |
| enq_ready | output | 1 | Queue can accept an entry |
| ref_cmd | input | 1 | One-cycle pulse: periodic refresh command seen |
| vref_valid | output | 1 | Refresh the row on `vref_row` this cycle |
| vref_row | output | ROW_W | Victim row address |
| alert_n | output | 1 | Active-low request for the controller to pause |
| busy | output | 1 | Victim sweep in progress |

## Verification
Every result is due at a fixed cycle offset from its stimulus:
- The first victim slot follows a refresh-command edge by one cycle, and each later slot follows by one more, with skipped slots still counted.
- `enq_ready` drops in the cycle after the filling push.
- `alert_n` falls one edge later still.
- Self-started service begins on the edge after that.

The bench drives inputs and samples outputs on the falling edge. It logs each strobe with the rising-edge count at which it became visible. Checks compare those stamps against offsets worked out from the command cycle, and they count how many strobes had appeared when `alert_n` rose.

// File: rtl/rhq_pkg.sv
`timescale 1ns/1ps
// Shared types for the victim-refresh scheduler.
package rhq_pkg;
    // Sweep engine state: waiting for a trigger, or stepping victim slots.
    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sweep_state_e;
endpackage

// File: rtl/rhq_fifo.sv
`timescale 1ns/1ps
// In-order store for aggressor row addresses.
// Assumes: the caller never pushes when full nor pops when empty.
// The head entry is readable combinationally.
module rhq_fifo #(
    parameter int ROW_W = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ROW_W-1:0] push_row,
    input  logic             pop,
    output logic [ROW_W-1:0] head_row,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [ROW_W-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;

    // Advance a pointer with wrap at DEPTH-1.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Data array write; needs no reset.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_row;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Status and head outputs.
    always_comb begin
        head_row = store[rd_ptr];
        count    = cnt_q;
        full     = (cnt_q == CNT_W'(DEPTH));
        empty    = (cnt_q == '0);
    end

    // R1
    fifo_hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(DEPTH) && !pop) |=> (cnt_q == CNT_W'(DEPTH)));

    // R1
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/rhq_alert.sv
`timescale 1ns/1ps
// Back-pressure flag with hysteresis.
// Sets when occupancy reaches DEPTH and clears when it drops below LOW_MARK.
// Assumes 1 <= LOW_MARK <= DEPTH.
module rhq_alert #(
    parameter int DEPTH    = 4,
    parameter int LOW_MARK = 2,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    output logic             alert_on
);
    // Hysteresis register for the pause request.
    always_ff @(posedge clk) begin
        if (!rst_n)                          alert_on <= 1'b0;
        else if (count == CNT_W'(DEPTH))     alert_on <= 1'b1;
        else if (count < CNT_W'(LOW_MARK))   alert_on <= 1'b0;
    end

    // R7
    alert_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_on) |-> ($past(count) == CNT_W'(DEPTH)));

    // R8
    alert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_on && count >= CNT_W'(LOW_MARK)) |=> alert_on);
endmodule

// File: rtl/rhq_sweep.sv
`timescale 1ns/1ps
// Expands each popped aggressor into victim slots A-R..A-1, A+1..A+R.
// Emits one slot per cycle; out-of-range slots strobe nothing.
// Starts on a refresh command (grant of PER_REF entries) or while the alert holds.
// Assumes RADIUS < 2**ROW_W and NUM_ROWS <= 2**ROW_W.
module rhq_sweep
    import rhq_pkg::*;
#(
    parameter int ROW_W    = 8,
    parameter int NUM_ROWS = 200,
    parameter int RADIUS   = 2,
    parameter int PER_REF  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_cmd,
    input  logic             alert_on,
    input  logic             q_empty,
    input  logic [ROW_W-1:0] head_row,
    output logic             pop,
    output logic             vref_valid,
    output logic [ROW_W-1:0] vref_row,
    output logic             busy
);
    localparam int OFF_W = $clog2(RADIUS + 1) + 1;
    localparam int GR_W  = $clog2(PER_REF + 1);
    localparam int VW    = ROW_W + 2;
    localparam logic [OFF_W-1:0] OFF_LO = OFF_W'(-RADIUS);
    localparam logic [OFF_W-1:0] OFF_HI = OFF_W'(RADIUS);

    sweep_state_e     state_q;
    logic [ROW_W-1:0] agg_q;
    logic [OFF_W-1:0] off_q;
    logic [GR_W-1:0]  grant_q;
    logic             last_slot, start, chain;
    logic [OFF_W-1:0] off_next;
    logic [VW-1:0]    victim;
    logic             in_range;

    // Slot stepping and trigger decode.
    always_comb begin
        last_slot = (off_q == OFF_HI);
        off_next  = (&off_q) ? OFF_W'(1) : off_q + OFF_W'(1);
        start     = (state_q == SW_IDLE) && !q_empty && (ref_cmd || alert_on);
        chain     = (state_q == SW_RUN) && last_slot && !q_empty
                    && (alert_on || grant_q != '0);
        pop       = start || chain;
    end

    // Victim address and range test (two's-complement offset).
    always_comb begin
        victim     = {2'b00, agg_q} + {{(VW - OFF_W){off_q[OFF_W-1]}}, off_q};
        in_range   = !victim[VW-1] && (victim < VW'(NUM_ROWS));
        busy       = (state_q == SW_RUN);
        vref_valid = busy && in_range;
        vref_row   = victim[ROW_W-1:0];
    end

    // Sweep sequencer: load aggressors, step offsets, spend the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            agg_q   <= '0;
            off_q   <= '0;
            grant_q <= '0;
        end else begin
            case (state_q)
                SW_IDLE: begin
                    if (start) begin
                        state_q <= SW_RUN;
                        agg_q   <= head_row;
                        off_q   <= OFF_LO;
                        grant_q <= ref_cmd ? GR_W'(PER_REF - 1) : '0;
                    end
                end
                SW_RUN: begin
                    if (!last_slot) begin
                        off_q <= off_next;
                    end else if (chain) begin
                        agg_q   <= head_row;
                        off_q   <= OFF_LO;
                        grant_q <= (grant_q != '0) ? grant_q - GR_W'(1) : '0;
                    end else begin
                        state_q <= SW_IDLE;
                    end
                end
                default: state_q <= SW_IDLE;
            endcase
        end
    end

    // R2
    sweep_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ref_cmd && !alert_on) |=> !busy);

    // R3
    sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ref_cmd && !q_empty) |=> busy);

    // R9
    sweep_alert_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && alert_on && !q_empty) |=> busy);

    // R10
    sweep_strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vref_valid |-> busy);

    // R3
    sweep_not_aggressor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vref_valid |-> (vref_row != agg_q));
endmodule

// File: rtl/rh_victim_sched.sv
`timescale 1ns/1ps
// Rowhammer victim-refresh scheduler top.
// Queues aggressor rows, sweeps their neighbours on refresh commands,
// and raises an active-low pause request when the queue fills.
// Assumes ref_cmd is a single-cycle pulse.
module rh_victim_sched #(
    parameter int ROW_W    = 8,
    parameter int NUM_ROWS = 200,
    parameter int DEPTH    = 4,
    parameter int RADIUS   = 2,
    parameter int PER_REF  = 2,
    parameter int LOW_MARK = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic [ROW_W-1:0] enq_row,
    output logic             enq_ready,
    input  logic             ref_cmd,
    output logic             vref_valid,
    output logic [ROW_W-1:0] vref_row,
    output logic             alert_n,
    output logic             busy
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             q_push, q_pop, q_full, q_empty, alert_on;
    logic [ROW_W-1:0] q_head;
    logic [CNT_W-1:0] q_count;

    // Front-end handshake and alert polarity.
    always_comb begin
        enq_ready = !q_full;
        q_push    = enq_valid && !q_full;
        alert_n   = !alert_on;
    end

    rhq_fifo #(.ROW_W(ROW_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push),
        .push_row (enq_row),
        .pop      (q_pop),
        .head_row (q_head),
        .count    (q_count),
        .full     (q_full),
        .empty    (q_empty)
    );

    rhq_alert #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) u_alert (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (q_count),
        .alert_on (alert_on)
    );

    rhq_sweep #(
        .ROW_W(ROW_W), .NUM_ROWS(NUM_ROWS), .RADIUS(RADIUS), .PER_REF(PER_REF)
    ) u_sweep (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_cmd    (ref_cmd),
        .alert_on   (alert_on),
        .q_empty    (q_empty),
        .head_row   (q_head),
        .pop        (q_pop),
        .vref_valid (vref_valid),
        .vref_row   (vref_row),
        .busy       (busy)
    );

    // R1
    top_ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enq_ready && !busy) |=> !enq_ready || busy);
endmodule

// File: tb/rh_victim_sched_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module rh_victim_sched_bench;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       enq_valid = 1'b0, ref_cmd = 1'b0;
    logic [7:0] enq_row = '0;
    logic       enq_ready, vref_valid, alert_n, busy;
    logic [7:0] vref_row;

    rh_victim_sched u_rh_victim_sched (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_row(enq_row),
        .enq_ready(enq_ready), .ref_cmd(ref_cmd), .vref_valid(vref_valid),
        .vref_row(vref_row), .alert_n(alert_n), .busy(busy)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int   log_row [64];
    int   log_cyc [64];
    int   log_n = 0;
    int   rise_at = -1;
    logic alert_prev = 1'b1;
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    // Strobe logger and alert-release marker, on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (vref_valid && log_n < 64) begin
                log_row[log_n] = int'(vref_row);
                log_cyc[log_n] = cyc;
                log_n = log_n + 1;
            end
            if (alert_n && !alert_prev) rise_at = log_n;
            alert_prev = alert_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int row);
        @(negedge clk); enq_valid = 1'b1; enq_row = row[7:0];
        @(negedge clk); enq_valid = 1'b0;
    endtask

    task automatic ref_pulse(output int t);
        @(negedge clk); ref_cmd = 1'b1; t = cyc;
        @(negedge clk); ref_cmd = 1'b0;
    endtask

    task automatic expect_rows(input int base, input int exp_q[$], input string req);
        chk(log_n - base == exp_q.size(), req, log_n - base, exp_q.size());
        for (int i = 0; i < exp_q.size(); i++)
            if (base + i < log_n)
                chk(log_row[base + i] == exp_q[i], req, log_row[base + i], exp_q[i]);
    endtask

    task automatic t_reset();
        chk(enq_ready == 1'b1, "R12", int'(enq_ready), 1);
        chk(alert_n == 1'b1, "R12", int'(alert_n), 1);
        chk(busy == 1'b0, "R12", int'(busy), 0);
        chk(vref_valid == 1'b0, "R12", int'(vref_valid), 0);
    endtask

    task automatic t_basic();
        int b, t;
        int e[$];
        b = log_n;
        push(50);
        repeat (5) @(negedge clk);
        chk(log_n == b, "R2", log_n - b, 0);
        chk(busy == 1'b0, "R2", int'(busy), 0);
        ref_pulse(t);
        repeat (6) @(negedge clk);
        e = '{48, 49, 51, 52};
        expect_rows(b, e, "R3");
        chk(log_cyc[b] == t + 1, "R3", log_cyc[b], t + 1);
        chk(log_cyc[b + 3] == t + 4, "R3", log_cyc[b + 3], t + 4);
        chk(busy == 1'b0, "R10", int'(busy), 0);
    endtask

    task automatic t_edges();
        int b, t;
        int e[$];
        b = log_n;
        push(0);
        push(199);
        ref_pulse(t);
        repeat (10) @(negedge clk);
        e = '{1, 2, 197, 198};
        expect_rows(b, e, "R4");
        chk(log_cyc[b] == t + 3, "R4", log_cyc[b], t + 3);
        chk(log_cyc[b + 2] == t + 5, "R4", log_cyc[b + 2], t + 5);
    endtask

    task automatic t_budget();
        int b, t;
        int e[$];
        b = log_n;
        push(10); push(20); push(30);
        @(negedge clk); ref_cmd = 1'b1; t = cyc;
        @(negedge clk); ref_cmd = 1'b0;
        chk(busy == 1'b1, "R10", int'(busy), 1);
        @(negedge clk);
        @(negedge clk); ref_cmd = 1'b1;          // R11: command while busy
        @(negedge clk); ref_cmd = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy == 1'b1, "R10", int'(busy), 1);
        @(negedge clk);
        chk(busy == 1'b0, "R5", int'(busy), 0);
        repeat (20) @(negedge clk);
        e = '{8, 9, 11, 12, 18, 19, 21, 22};
        expect_rows(b, e, "R6");
        chk(log_n - b == 8, "R11", log_n - b, 8);
        chk(log_cyc[b + 4] == t + 5, "R5", log_cyc[b + 4], t + 5);
        b = log_n;
        ref_pulse(t);
        repeat (8) @(negedge clk);
        e = '{28, 29, 31, 32};
        expect_rows(b, e, "R5");
    endtask

    task automatic t_alert();
        int b, t;
        int e[$];
        b = log_n;
        @(negedge clk); enq_valid = 1'b1; enq_row = 8'd100;
        @(negedge clk); enq_row = 8'd110;
        @(negedge clk); enq_row = 8'd120;
        @(negedge clk); enq_row = 8'd130;
        @(negedge clk); enq_row = 8'd140;
        chk(enq_ready == 1'b0, "R1", int'(enq_ready), 0);
        chk(alert_n == 1'b1, "R7", int'(alert_n), 1);
        @(negedge clk);
        chk(alert_n == 1'b0, "R7", int'(alert_n), 0);
        chk(busy == 1'b0, "R9", int'(busy), 0);
        @(negedge clk);
        chk(busy == 1'b1, "R9", int'(busy), 1);
        chk(enq_ready == 1'b1, "R1", int'(enq_ready), 1);
        @(negedge clk); enq_valid = 1'b0;
        repeat (30) @(negedge clk);
        e = '{98, 99, 101, 102, 108, 109, 111, 112,
              118, 119, 121, 122, 128, 129, 131, 132};
        expect_rows(b, e, "R9");
        chk(rise_at - b == 14, "R8", rise_at - b, 14);
        chk(alert_n == 1'b1, "R8", int'(alert_n), 1);
        chk(busy == 1'b0, "R9", int'(busy), 0);
        b = log_n;
        ref_pulse(t);
        repeat (8) @(negedge clk);
        e = '{138, 139, 141, 142};
        expect_rows(b, e, "R1");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Scenario sequence.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_edges();
        t_budget();
        t_alert();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule